// File: doc/BRIEF.md
# Jitter Attenuator Elastic FIFO

This block takes serial data that arrives with an irregular rhythm and hands it on with evenly spaced timing. Every input bit comes with a one-cycle write strobe, and the bit goes into a one-bit-wide elastic buffer. A phase-accumulator oscillator produces the read strobes. Each read strobe takes the oldest bit out of the buffer. The amount added to the accumulator on every cycle is a nominal step plus a correction that grows with the distance between the fill level and half depth. The average output rate therefore locks onto the average input rate, while short-term timing wander is filtered out.

The buffer can be 32, 64 or 128 bits deep. After a reset or a change of depth the buffer is emptied. Reading then stays off until the buffer is half full, so the delay starts centred. An optional guard mode overrides the filtered rate when the fill comes close to either end. Near full it reads at the fastest allowed rate, and near empty it stops reading. The width of the guard band depends on the depth. A bandwidth input picks a fast or a slow loop. Sticky flags record write-on-full and read-on-empty events until a clear pulse removes them.

Top module: `jit_elastic_fifo`

## Requirements
- R1: While reset is high and on the first cycle after it, `rd_stb`, `rd_bit`, `ovf_flag`, `udf_flag` and `fill_lvl` are all zero.
- R2: `depth_sel` sets the depth: 0 gives 32, 1 gives 64, and 2 or 3 give 128. No read strobe appears until `fill_lvl` has reached half the depth.
- R3: Bits leave on `rd_bit`, flagged by `rd_stb`, in the same order they were written.
- R4: A write strobe that arrives while the fill equals the depth discards its bit and sets `ovf_flag` on the next cycle. `fill_lvl` never goes above the depth.
- R5: A read strobe that occurs while the buffer is empty gives `rd_bit` = 0, leaves the fill unchanged and sets `udf_flag` in the same cycle as that `rd_stb`.
- R6: `ovf_flag` and `udf_flag` stay set until a cycle with `sticky_clr` high clears them. A set event in the same cycle as the clear wins.
- R7: When `limit_en` is high and the fill is at or below the guard band (2, 3 or 4 bits for depths 32, 64 and 128), reading stops, so a buffer that receives no writes settles at exactly the guard value.
- R8: When `limit_en` is high and the fill is at or above depth minus the guard, reads are forced to every other cycle. An input rate that overflows the buffer with `limit_en` low then causes no overflow.
- R9: With `bw_narrow` low, the loop reacts more strongly to fill error than with `bw_narrow` high, so a buffer that is above half full drains faster.
- R10: On a change of `depth_sel`, the next cycle shows `fill_lvl` = 0 and no read strobe. Reading then stays off until half of the new depth is reached.
- R11: Writes at the nominal rate keep the fill within 8 of half depth and set no flag.
- R12: `rd_stb` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| depth_sel | input | 2 | Depth code (0: 32, 1: 64, 2/3: 128) |
| limit_en | input | 1 | Guard-band rate override enable |
| bw_narrow | input | 1 | 1 selects the slow tracking loop |
| wr_stb | input | 1 | Input bit valid strobe |
| wr_bit | input | 1 | Input data bit |
| sticky_clr | input | 1 | One-cycle clear of both sticky flags |
| rd_stb | output | 1 | Output bit valid strobe |
| rd_bit | output | 1 | Output data bit (0 outside strobes and on underflow) |
| ovf_flag | output | 1 | Sticky write-on-full flag |
| udf_flag | output | 1 | Sticky read-on-empty flag |
| fill_lvl | output | 8 | Current number of stored bits |

## Verification
The bench uses the default parameters. The accumulator is 16 bits wide and the nominal step is 8192, so there is one read about every 8 cycles. The error gain is a left shift of 10 followed by a right shift of 2 for the fast loop or 4 for the slow loop. With read spacing of only a few cycles, the bench can fill all three depths, reach both guard bands and drain to underflow within a few thousand cycles. The correction stays large enough that the drain rates of the two loop settings differ by several reads over a 96-cycle window.

// File: rtl/jef_pkg.sv
package jef_pkg;

    localparam int MAX_DEPTH = 128;
    localparam int CNT_W     = $clog2(MAX_DEPTH + 1);
    localparam int PTR_W     = $clog2(MAX_DEPTH);

    typedef enum logic [1:0] {
        DSEL_32   = 2'd0,
        DSEL_64   = 2'd1,
        DSEL_128  = 2'd2,
        DSEL_128B = 2'd3
    } depth_code_e;

    typedef struct packed {
        logic [CNT_W-1:0] depth;
        logic [CNT_W-1:0] half;
        logic [CNT_W-1:0] guard;
    } depth_cfg_t;

    typedef struct packed {
        logic ovf;
        logic udf;
    } fifo_evt_t;

    function automatic depth_cfg_t decode_depth(input logic [1:0] code);
        depth_cfg_t c;
        unique case (depth_code_e'(code))
            DSEL_32: begin
                c.depth = CNT_W'(32);
                c.guard = CNT_W'(2);
            end
            DSEL_64: begin
                c.depth = CNT_W'(64);
                c.guard = CNT_W'(3);
            end
            default: begin
                c.depth = CNT_W'(128);
                c.guard = CNT_W'(4);
            end
        endcase
        c.half = c.depth >> 1;
        return c;
    endfunction

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p,
                                                  input logic [CNT_W-1:0] depth);
        logic [CNT_W-1:0] last;
        last = depth - CNT_W'(1);
        return (p == last[PTR_W-1:0]) ? '0 : p + PTR_W'(1);
    endfunction

endpackage

// File: rtl/jef_bitstore.sv
module jef_bitstore
    import jef_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [CNT_W-1:0] depth,
    input  logic             wr_en,
    input  logic             wr_bit,
    input  logic             rd_req,
    output logic             rd_data,
    output logic             rd_ok,
    output logic [CNT_W-1:0] fill,
    output fifo_evt_t        evt
);

    logic [MAX_DEPTH-1:0] mem;
    logic [PTR_W-1:0]     wr_ptr;
    logic [PTR_W-1:0]     rd_ptr;
    logic [CNT_W-1:0]     cnt;
    logic                 full;
    logic                 empty;
    logic                 wr_ok;

    assign full    = (cnt == depth);
    assign empty   = (cnt == '0);
    assign wr_ok   = wr_en & ~full;
    assign rd_ok   = rd_req & ~empty;
    assign evt.ovf = wr_en & full;
    assign evt.udf = rd_req & empty;
    assign rd_data = mem[rd_ptr];
    assign fill    = cnt;

    always_ff @(posedge clk) begin
        if (wr_ok) begin
            mem[wr_ptr] <= wr_bit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (wr_ok) begin
                wr_ptr <= ptr_step(wr_ptr, depth);
            end
            if (rd_ok) begin
                rd_ptr <= ptr_step(rd_ptr, depth);
            end
            unique case ({wr_ok, rd_ok})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/jef_nco.sv
module jef_nco
    import jef_pkg::*;
#(
    parameter int ACC_W      = 16,
    parameter int NOM_INC    = 8192,
    parameter int CORR_LSH   = 10,
    parameter int WIDE_RSH   = 2,
    parameter int NARROW_RSH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] fill,
    input  depth_cfg_t       cfg,
    input  logic             limit_en,
    input  logic             bw_narrow,
    output logic             tick
);

    localparam int FAST_INC = 1 << (ACC_W - 1);
    localparam int MIN_INC  = NOM_INC >> 3;

    logic [ACC_W-1:0] acc;
    logic [ACC_W-1:0] inc;
    logic [ACC_W:0]   sum;
    logic             near_full;
    logic             near_empty;

    assign near_full  = limit_en && (fill >= (cfg.depth - cfg.guard));
    assign near_empty = limit_en && (fill <= cfg.guard);

    always_comb begin
        int err;
        int corr;
        int step;
        err  = int'(fill) - int'(cfg.half);
        corr = (err <<< CORR_LSH) >>> (bw_narrow ? NARROW_RSH : WIDE_RSH);
        step = NOM_INC + corr;
        if (step < MIN_INC) begin
            step = MIN_INC;
        end else if (step > FAST_INC) begin
            step = FAST_INC;
        end
        if (near_full) begin
            step = FAST_INC;
        end else if (near_empty) begin
            step = 0;
        end
        inc = ACC_W'(step);
    end

    assign sum  = {1'b0, acc} + {1'b0, inc};
    assign tick = run & sum[ACC_W];

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            acc <= '0;
        end else begin
            acc <= sum[ACC_W-1:0];
        end
    end

endmodule

// File: rtl/jef_sticky.sv
module jef_sticky
    import jef_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  fifo_evt_t set_evt,
    input  logic      clr,
    output fifo_evt_t flags
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags.ovf <= set_evt.ovf | (flags.ovf & ~clr);
            flags.udf <= set_evt.udf | (flags.udf & ~clr);
        end
    end

endmodule

// File: rtl/jit_elastic_fifo.sv
module jit_elastic_fifo
    import jef_pkg::*;
#(
    parameter int ACC_W      = 16,
    parameter int NOM_INC    = 8192,
    parameter int CORR_LSH   = 10,
    parameter int WIDE_RSH   = 2,
    parameter int NARROW_RSH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       depth_sel,
    input  logic             limit_en,
    input  logic             bw_narrow,
    input  logic             wr_stb,
    input  logic             wr_bit,
    input  logic             sticky_clr,
    output logic             rd_stb,
    output logic             rd_bit,
    output logic             ovf_flag,
    output logic             udf_flag,
    output logic [CNT_W-1:0] fill_lvl
);

    logic [1:0]       depth_q;
    logic             flush;
    depth_cfg_t       cfg;
    logic             primed;
    logic             run;
    logic             tick;
    logic             rd_data;
    logic             rd_ok;
    logic [CNT_W-1:0] fill;
    fifo_evt_t        evt;
    fifo_evt_t        flags;
    logic             rd_stb_q;
    logic             rd_bit_q;

    assign flush = (depth_sel != depth_q);
    assign cfg   = decode_depth(depth_q);
    assign run   = primed & ~flush;

    always_ff @(posedge clk) begin
        if (rst) begin
            depth_q  <= depth_sel;
            primed   <= 1'b0;
            rd_stb_q <= 1'b0;
            rd_bit_q <= 1'b0;
        end else begin
            depth_q  <= depth_sel;
            if (flush) begin
                primed <= 1'b0;
            end else if (fill >= cfg.half) begin
                primed <= 1'b1;
            end
            rd_stb_q <= tick;
            rd_bit_q <= rd_ok & rd_data;
        end
    end

    jef_bitstore u_store (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .depth   (cfg.depth),
        .wr_en   (wr_stb & ~flush),
        .wr_bit  (wr_bit),
        .rd_req  (tick),
        .rd_data (rd_data),
        .rd_ok   (rd_ok),
        .fill    (fill),
        .evt     (evt)
    );

    jef_nco #(
        .ACC_W      (ACC_W),
        .NOM_INC    (NOM_INC),
        .CORR_LSH   (CORR_LSH),
        .WIDE_RSH   (WIDE_RSH),
        .NARROW_RSH (NARROW_RSH)
    ) u_nco (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .fill      (fill),
        .cfg       (cfg),
        .limit_en  (limit_en),
        .bw_narrow (bw_narrow),
        .tick      (tick)
    );

    jef_sticky u_sticky (
        .clk     (clk),
        .rst     (rst),
        .set_evt (evt),
        .clr     (sticky_clr),
        .flags   (flags)
    );

    assign rd_stb   = rd_stb_q;
    assign rd_bit   = rd_bit_q;
    assign ovf_flag = flags.ovf;
    assign udf_flag = flags.udf;
    assign fill_lvl = fill;

endmodule

// File: rtl/jit_elastic_fifo_chk.sv
module jit_elastic_fifo_chk
    import jef_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [1:0]       depth_sel,
    input logic             limit_en,
    input logic             wr_stb,
    input logic             sticky_clr,
    input logic             rd_stb,
    input logic             rd_bit,
    input logic             ovf_flag,
    input logic             udf_flag,
    input logic [CNT_W-1:0] fill_lvl
);

    depth_cfg_t sel_cfg;
    assign sel_cfg = decode_depth(depth_sel);

    // R4
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        $stable(depth_sel) |-> fill_lvl <= sel_cfg.depth);

    // R4
    ovf_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_flag) |-> $past(wr_stb) && ($past(fill_lvl) >= CNT_W'(32)));

    // R5
    udf_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(udf_flag) |-> rd_stb && !rd_bit);

    // R6
    ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ovf_flag) |-> $past(sticky_clr));

    // R6
    udf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(udf_flag) |-> $past(sticky_clr));

    // R7
    limit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        limit_en && $stable(depth_sel) && (fill_lvl <= sel_cfg.guard) |=> !rd_stb);

    // R10
    depth_flush_chk: assert property (@(posedge clk) disable iff (rst)
        (depth_sel != $past(depth_sel)) |=> (fill_lvl == '0) && !rd_stb);

    // R12
    strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
        rd_stb |=> !rd_stb);

endmodule

bind jit_elastic_fifo jit_elastic_fifo_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .depth_sel  (depth_sel),
    .limit_en   (limit_en),
    .wr_stb     (wr_stb),
    .sticky_clr (sticky_clr),
    .rd_stb     (rd_stb),
    .rd_bit     (rd_bit),
    .ovf_flag   (ovf_flag),
    .udf_flag   (udf_flag),
    .fill_lvl   (fill_lvl)
);

// File: tb/jit_elastic_fifo_tb.sv
module jit_elastic_fifo_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] depth_sel = 2'd0;
    logic       limit_en = 1'b0;
    logic       bw_narrow = 1'b0;
    logic       wr_stb = 1'b0;
    logic       wr_bit = 1'b0;
    logic       sticky_clr = 1'b0;
    logic       rd_stb;
    logic       rd_bit;
    logic       ovf_flag;
    logic       udf_flag;
    logic [7:0] fill_lvl;

    int  nvec = 0;
    int  nerr = 0;
    int  nreads = 0;
    int  back2back = 0;
    int  max_fill = 0;
    int  min_fill = 255;
    bit  prev_rd = 1'b0;
    bit  done = 1'b0;
    bit  got_q[$];
    bit  exp_q[$];

    always #10 clk = ~clk;

    jit_elastic_fifo u_dut (
        .clk        (clk),
        .rst        (rst),
        .depth_sel  (depth_sel),
        .limit_en   (limit_en),
        .bw_narrow  (bw_narrow),
        .wr_stb     (wr_stb),
        .wr_bit     (wr_bit),
        .sticky_clr (sticky_clr),
        .rd_stb     (rd_stb),
        .rd_bit     (rd_bit),
        .ovf_flag   (ovf_flag),
        .udf_flag   (udf_flag),
        .fill_lvl   (fill_lvl)
    );

    task automatic check(input string req, input int act, input int exp_v);
        nvec++;
        if (act != exp_v) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic step(input logic w, input logic b);
        wr_stb = w;
        wr_bit = b;
        @(posedge clk);
        @(negedge clk);
        wr_stb = 1'b0;
        wr_bit = 1'b0;
        if (rd_stb) begin
            got_q.push_back(rd_bit);
            nreads++;
            if (prev_rd) back2back++;
        end
        prev_rd = rd_stb;
        if (int'(fill_lvl) > max_fill) max_fill = int'(fill_lvl);
        if (int'(fill_lvl) < min_fill) min_fill = int'(fill_lvl);
    endtask

    task automatic clear_stats();
        nreads = 0;
        back2back = 0;
        max_fill = 0;
        min_fill = 255;
        got_q.delete();
        exp_q.delete();
    endtask

    task automatic do_reset(input logic [1:0] d, input logic lim, input logic nb);
        depth_sel = d;
        limit_en = lim;
        bw_narrow = nb;
        sticky_clr = 1'b0;
        rst = 1'b1;
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0);
        rst = 1'b0;
        clear_stats();
    endtask

    function automatic bit pat(input int i);
        return bit'(((i * 5) >> 1) & 1) ^ bit'((i % 3) == 0);
    endfunction

    task automatic t_reset();
        do_reset(2'd0, 1'b0, 1'b0);
        check("R1 rd_stb", int'(rd_stb), 0);
        check("R1 rd_bit", int'(rd_bit), 0);
        check("R1 ovf_flag", int'(ovf_flag), 0);
        check("R1 udf_flag", int'(udf_flag), 0);
        check("R1 fill_lvl", int'(fill_lvl), 0);
    endtask

    task automatic t_prime();
        do_reset(2'd0, 1'b0, 1'b0);
        for (int i = 0; i < 15; i++) step(1'b1, 1'b1);
        for (int i = 0; i < 60; i++) step(1'b0, 1'b0);
        check("R2 no read below half", nreads, 0);
        step(1'b1, 1'b1);
        check("R2 fill at half of 32", int'(fill_lvl), 16);
        for (int i = 0; i < 40; i++) step(1'b0, 1'b0);
        check("R2 reading starts at half", int'(nreads > 0), 1);
    endtask

    task automatic t_order();
        int bad;
        do_reset(2'd0, 1'b0, 1'b0);
        for (int i = 0; i < 16; i++) begin
            exp_q.push_back(pat(i));
            step(1'b1, pat(i));
        end
        max_fill = 0;
        min_fill = 255;
        for (int i = 16; i < 300; i++) begin
            exp_q.push_back(pat(i));
            step(1'b1, pat(i));
            for (int k = 0; k < 7; k++) step(1'b0, 1'b0);
        end
        bad = 0;
        for (int k = 0; k < got_q.size(); k++) begin
            if (got_q[k] != exp_q[k]) bad++;
        end
        check("R3 enough bits out", int'(got_q.size() >= 250), 1);
        check("R3 order mismatches", bad, 0);
        check("R11 ovf_flag", int'(ovf_flag), 0);
        check("R11 udf_flag", int'(udf_flag), 0);
        check("R11 min fill >= 8", int'(min_fill >= 8), 1);
        check("R11 max fill <= 24", int'(max_fill <= 24), 1);
    endtask

    task automatic t_over_under();
        int guard;
        do_reset(2'd0, 1'b0, 1'b0);
        for (int i = 0; i < 60; i++) step(1'b1, 1'b1);
        check("R4 ovf_flag set", int'(ovf_flag), 1);
        check("R4 max fill equals depth", max_fill, 32);
        sticky_clr = 1'b1;
        step(1'b0, 1'b0);
        sticky_clr = 1'b0;
        check("R6 ovf cleared", int'(ovf_flag), 0);
        guard = 0;
        while (fill_lvl != 8'd0 && guard < 3000) begin
            step(1'b0, 1'b0);
            guard++;
        end
        check("R5 drained", int'(fill_lvl), 0);
        check("R5 udf before empty read", int'(udf_flag), 0);
        guard = 0;
        do begin
            step(1'b0, 1'b0);
            guard++;
        end while (!rd_stb && guard < 200);
        check("R5 read strobe on empty", int'(rd_stb), 1);
        check("R5 rd_bit zero", int'(rd_bit), 0);
        check("R5 udf_flag set", int'(udf_flag), 1);
        check("R5 fill stays zero", int'(fill_lvl), 0);
        sticky_clr = 1'b1;
        guard = 0;
        do begin
            step(1'b0, 1'b0);
            guard++;
        end while (!rd_stb && guard < 200);
        check("R6 set wins over clear", int'(udf_flag), 1);
        step(1'b0, 1'b0);
        check("R6 udf cleared", int'(udf_flag), 0);
        sticky_clr = 1'b0;
    endtask

    task automatic t_limit_full();
        do_reset(2'd0, 1'b1, 1'b0);
        for (int i = 0; i < 200; i++) begin
            step(1'b1, 1'b1);
            step(1'b0, 1'b0);
            step(1'b0, 1'b0);
        end
        check("R8 no overflow in limit mode", int'(ovf_flag), 0);
        check("R8 guard band reached", int'(max_fill >= 30), 1);
        check("R12 no back-to-back strobes", back2back, 0);
        do_reset(2'd0, 1'b0, 1'b0);
        for (int i = 0; i < 200; i++) begin
            step(1'b1, 1'b1);
            step(1'b0, 1'b0);
            step(1'b0, 1'b0);
        end
        check("R8 overflow without limit", int'(ovf_flag), 1);
    endtask

    task automatic drain_count(input logic nb, output int cnt);
        do_reset(2'd0, 1'b0, nb);
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0);
        nreads = 0;
        for (int i = 0; i < 96; i++) step(1'b0, 1'b0);
        cnt = nreads;
    endtask

    task automatic t_bandwidth();
        int wide_n;
        int narrow_n;
        drain_count(1'b0, wide_n);
        drain_count(1'b1, narrow_n);
        check("R9 wide loop drains faster", int'(wide_n > narrow_n), 1);
    endtask

    task automatic t_limit_empty();
        do_reset(2'd0, 1'b1, 1'b0);
        for (int i = 0; i < 16; i++) step(1'b1, 1'b1);
        for (int i = 0; i < 600; i++) step(1'b0, 1'b0);
        check("R7 settles at guard 2", int'(fill_lvl), 2);
        check("R7 no underflow", int'(udf_flag), 0);
        depth_sel = 2'd1;
        step(1'b0, 1'b0);
        check("R10 flush to zero", int'(fill_lvl), 0);
        check("R10 no strobe after flush", int'(rd_stb), 0);
        nreads = 0;
        for (int i = 0; i < 31; i++) step(1'b1, 1'b1);
        check("R10 held below new half", nreads, 0);
        step(1'b1, 1'b1);
        check("R2 fill at half of 64", int'(fill_lvl), 32);
        for (int i = 0; i < 3000; i++) step(1'b0, 1'b0);
        check("R7 settles at guard 3", int'(fill_lvl), 3);
        depth_sel = 2'd2;
        step(1'b0, 1'b0);
        check("R10 flush at depth 128", int'(fill_lvl), 0);
        nreads = 0;
        for (int i = 0; i < 64; i++) step(1'b1, 1'b1);
        check("R2 no read below half of 128", nreads, 0);
        for (int i = 0; i < 6000; i++) step(1'b0, 1'b0);
        check("R7 settles at guard 4", int'(fill_lvl), 4);
        check("R7 no underflow at 128", int'(udf_flag), 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_prime();
        t_order();
        t_over_under();
        t_limit_full();
        t_bandwidth();
        t_limit_empty();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

endmodule